// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a virtual address into a physical address by consulting a single-level page table held in on-chip registers. The upper bits of the virtual address select a page descriptor. The lower bits pass through unchanged as the offset within the page. Each request also carries an access kind: data read, data write or instruction fetch. One clock later the block returns a physical address or a two-bit fault code.

Software-side logic fills the table through a direct write port and sets a table-length register. Before any descriptor is consulted, every page number is checked against that length. A descriptor holds a presence flag, a no-execute flag, a modified flag and a frame number. A successful write marks its page as modified. A read-back port exposes any descriptor so that its modified flag and other fields can be observed.

Top module: `paged_xlate`

## Requirements
- R1: After reset every descriptor reads back as zero, the table length is zero, and `rsp_valid`, `rsp_paddr` and `rsp_fault` are zero.
- R2: The page number is `req_vaddr[15:10]` and the offset is `req_vaddr[9:0]`. A successful translation returns `{frame, offset}`, with the frame taken from the descriptor at that page number.
- R3: A page number greater than or equal to the table length gives fault code 01. The table is not consulted, so even a write leaves the descriptor unchanged.
- R4: An in-range page whose presence flag (descriptor bit 6) is clear gives fault code 10.
- R5: An instruction fetch from a present page whose no-execute flag (descriptor bit 5) is set gives fault code 11. Reads and writes ignore that flag.
- R6: When several faults apply, 01 beats 10 and 10 beats 11. Code 00 means success.
- R7: A write that translates successfully sets the modified flag (descriptor bit 4) in the same cycle as its response. Reads, fetches and faulting writes leave the flag unchanged.
- R8: `rsp_valid` is high for exactly the one cycle after each cycle in which `req_valid` is high, and low otherwise.
- R9: `rsp_paddr` is zero whenever `rsp_fault` is nonzero.
- R10: A descriptor written through `tbl_we`/`tbl_idx`/`tbl_wdata` is laid out as {present[6], noexec[5], modified[4], frame[3:0]}. It reads back on `tbl_rdata` and governs requests from the next cycle on. If a table write and a modified-flag update hit the same entry in the same cycle, the table write wins.
- R11: Access kind encoding: 00 read, 01 write, 10 fetch. Code 11 behaves as a read.
- R12: `len_we` loads the table length from `len_val`. Any value above 64 acts as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_idx | input | 6 | Descriptor index to write |
| tbl_wdata | input | 7 | Descriptor value {present, noexec, modified, frame} |
| tbl_ridx | input | 6 | Descriptor index to read back |
| tbl_rdata | output | 7 | Read-back descriptor value (combinational) |
| len_we | input | 1 | Table-length load strobe |
| len_val | input | 7 | New table length, 0 to 127 |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 14 | Physical address, zero on fault |
| rsp_fault | output | 2 | Fault code |

## Verification
The response to a request driven before edge k is registered at edge k. The bench drives on the falling edge, so it samples `rsp_valid`, `rsp_paddr` and `rsp_fault` at the next falling edge. One falling edge later it confirms that `rsp_valid` has returned low. The modified flag is updated at the same edge as the response, so the read-back port is sampled at that same falling edge. Table and length writes take effect at the following edge, and requests that depend on them are issued only after it.

// File: rtl/vat_pkg.sv
package vat_pkg;
    parameter int VA_W  = 16;
    parameter int OFF_W = 10;
    parameter int PA_W  = 14;

    localparam int PN_W    = VA_W - OFF_W;
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int N_PAGES = 1 << PN_W;
    localparam int LEN_W   = PN_W + 1;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_BOUNDS = 2'b01,
        FLT_ABSENT = 2'b10,
        FLT_NOEXEC = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic               present;
        logic               noexec;
        logic               modified;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    // Fault decision in priority order: range, presence, execute permission.
    function automatic fault_e classify(input logic in_range, input pte_t e, input acc_e kind);
        if (!in_range)
            return FLT_BOUNDS;
        else if (!e.present)
            return FLT_ABSENT;
        else if (kind == ACC_FETCH && e.noexec)
            return FLT_NOEXEC;
        return FLT_NONE;
    endfunction
endpackage

// File: rtl/vat_len_reg.sv
module vat_len_reg
    import vat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_val,
    output logic [LEN_W-1:0] len_q
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(N_PAGES);

    always_ff @(posedge clk) begin
        if (rst)
            len_q <= '0;
        else if (len_we)
            len_q <= (len_val > LEN_MAX) ? LEN_MAX : len_val;
    end
endmodule

// File: rtl/vat_table.sv
module vat_table
    import vat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PN_W-1:0] wr_idx,
    input  pte_t            wr_data,
    input  logic            mark_en,
    input  logic [PN_W-1:0] mark_idx,
    input  logic            lkp_en,
    input  logic [PN_W-1:0] lkp_idx,
    output pte_t            lkp_pte,
    input  logic [PN_W-1:0] rb_idx,
    output pte_t            rb_pte
);
    pte_t entries [N_PAGES];

    for (genvar g = 0; g < N_PAGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entries[g] <= '0;
            else if (wr_en && wr_idx == PN_W'(g))
                entries[g] <= wr_data;
            else if (mark_en && mark_idx == PN_W'(g))
                entries[g].modified <= 1'b1;
        end
    end

    // An out-of-range lookup never touches the array.
    assign lkp_pte = lkp_en ? entries[lkp_idx] : '0;
    assign rb_pte  = entries[rb_idx];
endmodule

// File: rtl/vat_check.sv
module vat_check
    import vat_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  acc_e             kind,
    input  logic [LEN_W-1:0] len_q,
    input  pte_t             pte,
    output logic             in_range,
    output logic [PN_W-1:0]  pn,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr
);
    logic [OFF_W-1:0] off;

    always_comb begin
        pn       = vaddr[VA_W-1:OFF_W];
        off      = vaddr[OFF_W-1:0];
        in_range = {1'b0, pn} < len_q;
        fault    = classify(in_range, pte, kind);
        paddr    = (fault == FLT_NONE) ? {pte.frame, off} : '0;
    end
endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
    import vat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tbl_we,
    input  logic [PN_W-1:0]      tbl_idx,
    input  logic [PTE_W-1:0]     tbl_wdata,
    input  logic [PN_W-1:0]      tbl_ridx,
    output logic [PTE_W-1:0]     tbl_rdata,
    input  logic                 len_we,
    input  logic [LEN_W-1:0]     len_val,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [1:0]           req_kind,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic [1:0]           rsp_fault
);
    logic [LEN_W-1:0] len_q;
    logic             in_range;
    logic [PN_W-1:0]  pn;
    fault_e           fault_c;
    logic [PA_W-1:0]  paddr_c;
    pte_t             lkp_pte;
    pte_t             rb_pte;
    acc_e             kind;
    logic             mark_en;

    assign kind = acc_e'(req_kind);

    vat_len_reg u_len (
        .clk     (clk),
        .rst     (rst),
        .len_we  (len_we),
        .len_val (len_val),
        .len_q   (len_q)
    );

    vat_table u_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_data  (pte_t'(tbl_wdata)),
        .mark_en  (mark_en),
        .mark_idx (pn),
        .lkp_en   (in_range),
        .lkp_idx  (pn),
        .lkp_pte  (lkp_pte),
        .rb_idx   (tbl_ridx),
        .rb_pte   (rb_pte)
    );

    vat_check u_chk (
        .vaddr    (req_vaddr),
        .kind     (kind),
        .len_q    (len_q),
        .pte      (lkp_pte),
        .in_range (in_range),
        .pn       (pn),
        .fault    (fault_c),
        .paddr    (paddr_c)
    );

    assign mark_en   = req_valid && fault_c == FLT_NONE && kind == ACC_WRITE;
    assign tbl_rdata = rb_pte;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_paddr <= req_valid ? paddr_c : '0;
            rsp_fault <= req_valid ? fault_c : FLT_NONE;
        end
    end
endmodule

// File: rtl/paged_xlate_chk.sv
module paged_xlate_chk
    import vat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic [1:0]       req_kind,
    input logic [LEN_W-1:0] len_q,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_fault
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R8

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R8

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault != 2'b00) |-> (rsp_paddr == '0)); // R9

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rst) |=> (rsp_fault != 2'b00 ||
            rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R2

    AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && {1'b0, req_vaddr[VA_W-1:OFF_W]} >= len_q) |=> (rsp_fault == 2'b01)); // R3

    AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (rst)
        len_q <= LEN_W'(N_PAGES)); // R12

    AST_FETCH_ONLY_NOEXEC: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 2'b10) |=> (rsp_fault != 2'b11)); // R5
endmodule

bind paged_xlate paged_xlate_chk u_paged_xlate_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .req_kind  (req_kind),
    .len_q     (len_q),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/paged_xlate_bench.sv
module paged_xlate_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        tbl_we;
    logic [5:0]  tbl_idx;
    logic [6:0]  tbl_wdata;
    logic [5:0]  tbl_ridx;
    logic [6:0]  tbl_rdata;
    logic        len_we;
    logic [6:0]  len_val;
    logic        req_valid;
    logic [15:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        rsp_valid;
    logic [13:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [6:0] model [64];
    int         model_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_xlate u_paged_xlate (
        .clk(clk), .rst(rst),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .tbl_ridx(tbl_ridx), .tbl_rdata(tbl_rdata),
        .len_we(len_we), .len_val(len_val),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_pte(input int idx, input logic [6:0] val);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 6'(idx); tbl_wdata = val;
        @(negedge clk);
        tbl_we = 1'b0;
        model[idx] = val;
    endtask

    task automatic set_len(input int v);
        @(negedge clk);
        len_we = 1'b1; len_val = 7'(v);
        @(negedge clk);
        len_we = 1'b0;
        model_len = (v > 64) ? 64 : v;
    endtask

    // Issue one request, check the response one edge later, then the idle cycle.
    task automatic translate(input int pn, input int off, input int kind, input string tag);
        logic [1:0]  ef;
        logic [13:0] ea;
        logic [6:0]  e;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {6'(pn), 10'(off)};
        req_kind  = 2'(kind);
        tbl_ridx  = 6'(pn);
        e = model[pn];
        if (pn >= model_len)            ef = 2'b01;
        else if (!e[6])                 ef = 2'b10;
        else if (kind == 2 && e[5])     ef = 2'b11;
        else                            ef = 2'b00;
        ea = (ef == 2'b00) ? {e[3:0], 10'(off)} : 14'd0;
        if (ef == 2'b00 && kind == 1) model[pn][4] = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " fault"}, 32'(rsp_fault), 32'(ef));
        check({tag, " paddr"}, 32'(rsp_paddr), 32'(ea));
        check("R7 modified flag", 32'(tbl_rdata), 32'(model[pn]));
        @(negedge clk);
        check("R8 valid drops", 32'(rsp_valid), 32'd0);
    endtask

    function automatic string tag_for(input int pn, input int kind);
        logic [6:0] e = model[pn];
        if (pn >= model_len) return "R3 bounds";
        if (!e[6])           return "R4 absent";
        if (kind == 2 && e[5]) return "R5 noexec";
        if (kind == 3)       return "R11 rsvd kind";
        return "R2 translate";
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tbl_we = 0; tbl_idx = 0; tbl_wdata = 0; tbl_ridx = 0;
        len_we = 0; len_val = 0; req_valid = 0; req_vaddr = 0; req_kind = 0;
        for (int i = 0; i < 64; i++) model[i] = 7'd0;
        model_len = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 rsp_paddr", 32'(rsp_paddr), 32'd0);
        check("R1 rsp_fault", 32'(rsp_fault), 32'd0);
        for (int i = 0; i < 64; i++) begin
            tbl_ridx = 6'(i); #1;
            check("R1 descriptor", 32'(tbl_rdata), 32'd0);
        end
        translate(0, 5, 0, "R1 zero length");

        // R10: load a pattern; R6 includes entries hitting several faults
        for (int i = 0; i < 64; i++) begin
            logic [6:0] v;
            v[6]   = (i % 3) != 0;
            v[5]   = (i % 4) == 1 || (i % 4) == 2;
            v[4]   = 1'b0;
            v[3:0] = 4'(i ^ (i >> 2));
            write_pte(i, v);
            tbl_ridx = 6'(i); #1;
            check("R10 readback", 32'(tbl_rdata), 32'(v));
        end

        // R12 / R3: partial length sweep
        set_len(40);
        for (int p = 0; p < 64; p++)
            for (int k = 0; k < 4; k++)
                translate(p, (p * 37 + k * 211) % 1024, k, tag_for(p, k));

        // R12: over-range length clamps to 64
        set_len(100);
        for (int p = 0; p < 64; p++)
            for (int k = 0; k < 4; k++)
                translate(p, (p * 91 + k * 5 + 1023) % 1024, k, tag_for(p, k));

        // R3: length 63 leaves only the top page out
        set_len(63);
        translate(63, 1, 1, "R3 last page out");
        translate(62, 1023, 1, tag_for(62, 1));

        // R10: same-cycle table write beats modified-flag update
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {6'd4, 10'd9}; req_kind = 2'd1;
        tbl_we = 1'b1; tbl_idx = 6'd4; tbl_wdata = 7'b1000111;
        @(negedge clk);
        req_valid = 1'b0; tbl_we = 1'b0; tbl_ridx = 6'd4; #1;
        check("R10 write wins", 32'(tbl_rdata), 32'h47);
        model[4] = 7'b1000111;
        translate(4, 12, 2, "R10 new frame");

        // R6: absent with noexec set reports absent, not noexec
        write_pte(9, 7'b0100011);
        translate(9, 3, 2, "R6 priority");
        set_len(5);
        translate(9, 3, 2, "R6 bounds first");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule